// File: doc/BRIEF.md
# Dual-link even/odd pixel serializer

This block sits at the output of a display pipeline that delivers two 18-bit RGB pixels per pixel period: the first (even) and the second (odd) pixel of each horizontal pair. Each pixel goes to its own three-lane link. Every lane carries a 7-bit word per pixel period, shifted out one bit per serial slot. A fourth lane on each link forwards a fixed clock pattern that the receiver locks to. Only the even link carries horizontal sync, vertical sync and data-enable. The matching slots on the odd link are sent low.

The serial rate is modelled by a single fast clock with a bit enable, `bit_en`. Every enabled cycle advances every lane by one bit. A word boundary falls on the first enabled cycle after reset and then on every seventh enabled cycle. In that cycle the block raises `pix_take` and captures both pixels and the sync inputs. The source must hold its inputs valid in any cycle where `pix_take` can go high, and may change them freely between captures. The electrical layer and the clock multiplier lie outside this block. The nominal pixel rate of 81 MHz (53 to 83 MHz allowed) sets only the rate of `bit_en` and has no effect on the logic.

Top module: `dual_lvds_packer`

## Requirements
- R1: While `rst` is high, and after it until the first word is captured, all eight lane outputs are low.
- R2: `pix_take` is high only in a cycle with `bit_en` high and `rst` low. It goes high in the first such cycle after reset and then in every seventh `bit_en` cycle after that.
- R3: In a cycle with `bit_en` low, no lane output changes at the next clock edge.
- R4: After each capture, each clock lane sends the bits 1,1,0,0,0,1,1 in order, one per `bit_en` cycle.
- R5: Pixel buses are packed red [17:12], green [11:6], blue [5:0], with bit 5 of each colour as its MSB. Lane 0 of each link sends G0, R5, R4, R3, R2, R1, R0, in that order.
- R6: Lane 1 of each link sends B1, B0, G5, G4, G3, G2, G1, in that order.
- R7: Lane 2 of the even link sends data-enable, vertical sync, horizontal sync, B5, B4, B3, B2, in that order.
- R8: Lane 2 of the odd link sends three low bits and then B5, B4, B3, B2. The sync and enable inputs never reach the odd link.
- R9: The even link carries `even_pix` and the odd link carries `odd_pix`. Both clock lanes are identical in every cycle.
- R10: Each word holds the input values from its capture cycle. Input changes between captures do not affect the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Advances all lanes by one serial slot |
| even_pix | input | 18 | First pixel of the pair, {R,G,B} |
| odd_pix | input | 18 | Second pixel of the pair, {R,G,B} |
| hsync | input | 1 | Horizontal sync, sent on the even link only |
| vsync | input | 1 | Vertical sync, sent on the even link only |
| de | input | 1 | Data-enable, sent on the even link only |
| pix_take | output | 1 | High in the cycle in which the inputs are captured |
| even_lane | output | 3 | Serial data lanes 0..2 of the even link |
| even_clk | output | 1 | Forwarded clock lane of the even link |
| odd_lane | output | 3 | Serial data lanes 0..2 of the odd link |
| odd_clk | output | 1 | Forwarded clock lane of the odd link |

## Verification
The bench walks a single set bit across both pixel buses. A design with a reversed bit order or a swapped colour slot then sends the marker in the wrong slot or on the wrong lane. It toggles the sync and enable inputs with the pixels held at zero: an odd link that picked them up would show a high bit in its first three lane-2 slots. It removes `bit_en` at random and scrambles the inputs in every cycle, so a design that shifts without the enable, or that reads its inputs after the capture cycle, sends bits that differ from the words captured at `pix_take`. A reset in the middle of a word checks that the lanes fall low and that the next word starts with a fresh capture, not with the tail of the old word.

// File: rtl/lvds_pack_pkg.sv
package lvds_pack_pkg;
  localparam int COLOR_W = 6;
  localparam int PIX_W   = 3 * COLOR_W;
  localparam int WORD_W  = 7;
  localparam int LANES   = 3;
  localparam int CTL_W   = WORD_W - (COLOR_W - 2);

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
  } pix_t;

  typedef logic [WORD_W-1:0] word_t;

  // the word is sent MSB first, so the LSB-named colour bit leaves last
  function automatic word_t lane0_word(pix_t p);
    return {p.g[0], p.r};
  endfunction

  function automatic word_t lane1_word(pix_t p);
    return {p.b[1:0], p.g[COLOR_W-1:1]};
  endfunction

  // ctl is {de, vsync, hsync}; keep=0 forces the control slots low
  function automatic word_t lane2_word(pix_t p, logic [CTL_W-1:0] ctl, logic keep);
    return {ctl & {CTL_W{keep}}, p.b[COLOR_W-1:2]};
  endfunction
endpackage

// File: rtl/lvds_slot_ctr.sv
module lvds_slot_ctr #(
  parameter int WORD_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  output logic take
);
  localparam int SW = $clog2(WORD_W);
  localparam logic [SW-1:0] LAST = SW'(WORD_W - 1);

  logic [SW-1:0] slot;
  logic          primed;

  assign take = bit_en && !rst && (!primed || slot == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      primed <= 1'b0;
    end else if (take) begin
      slot   <= '0;
      primed <= 1'b1;
    end else if (bit_en) begin
      slot   <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/lvds_lane_ser.sv
module lvds_lane_ser #(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              load,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)         sh <= '0;
    else if (load)   sh <= word_i;
    else if (bit_en) sh <= {sh[WORD_W-2:0], 1'b0};
  end

  assign ser_o = sh[WORD_W-1];
endmodule

// File: rtl/lvds_link_mapper.sv
module lvds_link_mapper
  import lvds_pack_pkg::*;
#(
  parameter bit CARRY_CTL = 1'b1
) (
  input  pix_t                         pix_i,
  input  logic                         hsync,
  input  logic                         vsync,
  input  logic                         de,
  output logic [LANES-1:0][WORD_W-1:0] words_o
);
  assign words_o[0] = lane0_word(pix_i);
  assign words_o[1] = lane1_word(pix_i);
  assign words_o[2] = lane2_word(pix_i, {de, vsync, hsync}, CARRY_CTL);
endmodule

// File: rtl/dual_lvds_packer.sv
module dual_lvds_packer
  import lvds_pack_pkg::*;
#(
  parameter logic [WORD_W-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic [PIX_W-1:0] even_pix,
  input  logic [PIX_W-1:0] odd_pix,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             de,
  output logic             pix_take,
  output logic [LANES-1:0] even_lane,
  output logic             even_clk,
  output logic [LANES-1:0] odd_lane,
  output logic             odd_clk
);
  localparam int LINKS = 2;

  logic                    word_start;
  pix_t                    pix [LINKS];
  logic [LINKS-1:0][LANES:0] ser;

  assign pix[0] = pix_t'(even_pix);
  assign pix[1] = pix_t'(odd_pix);

  lvds_slot_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk(clk), .rst(rst), .bit_en(bit_en), .take(word_start)
  );

  for (genvar k = 0; k < LINKS; k++) begin : g_link
    logic [LANES-1:0][WORD_W-1:0] words;

    lvds_link_mapper #(.CARRY_CTL(k == 0)) u_map (
      .pix_i(pix[k]), .hsync(hsync), .vsync(vsync), .de(de), .words_o(words)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
      lvds_lane_ser #(.WORD_W(WORD_W)) u_ser (
        .clk(clk), .rst(rst), .bit_en(bit_en), .load(word_start),
        .word_i(words[j]), .ser_o(ser[k][j])
      );
    end

    lvds_lane_ser #(.WORD_W(WORD_W)) u_clk (
      .clk(clk), .rst(rst), .bit_en(bit_en), .load(word_start),
      .word_i(CLK_PATTERN), .ser_o(ser[k][LANES])
    );
  end

  assign pix_take  = word_start;
  assign even_lane = ser[0][LANES-1:0];
  assign even_clk  = ser[0][LANES];
  assign odd_lane  = ser[1][LANES-1:0];
  assign odd_clk   = ser[1][LANES];
endmodule

// File: rtl/lvds_packer_chk.sv
module lvds_packer_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_en,
  input logic       pix_take,
  input logic [2:0] even_lane,
  input logic       even_clk,
  input logic [2:0] odd_lane,
  input logic       odd_clk
);
  logic [2:0] since_take;
  logic       seen_take;
  logic [7:0] all_lanes;

  assign all_lanes = {odd_clk, odd_lane, even_clk, even_lane};

  always_ff @(posedge clk) begin
    if (rst) begin
      since_take <= '0;
      seen_take  <= 1'b0;
    end else if (pix_take) begin
      since_take <= '0;
      seen_take  <= 1'b1;
    end else if (bit_en) begin
      since_take <= since_take + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> all_lanes == 8'h00);

  // R2
  take_needs_en_chk: assert property (@(posedge clk) disable iff (rst) pix_take |-> bit_en);

  // R2
  take_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    pix_take |-> (!seen_take || since_take == 3'd6));

  // R2
  take_due_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && seen_take && since_take == 3'd6) |-> pix_take);

  // R3
  lanes_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(all_lanes));

  // R4
  clk_first_high_chk: assert property (@(posedge clk) disable iff (rst)
    pix_take |=> even_clk);

  // R8
  odd_ctl_low_chk: assert property (@(posedge clk) disable iff (rst)
    pix_take |=> !odd_lane[2]);

  // R9
  clk_lanes_equal_chk: assert property (@(posedge clk) disable iff (rst)
    even_clk == odd_clk);
endmodule

bind dual_lvds_packer lvds_packer_chk i_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .pix_take(pix_take),
  .even_lane(even_lane), .even_clk(even_clk),
  .odd_lane(odd_lane), .odd_clk(odd_clk)
);

// File: tb/test_dual_lvds_packer.sv
module test_dual_lvds_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic [17:0] even_pix = '0;
  logic [17:0] odd_pix = '0;
  logic        hsync = 1'b0, vsync = 1'b0, de = 1'b0;
  logic        pix_take;
  logic [2:0]  even_lane, odd_lane;
  logic        even_clk, odd_clk;

  int checks = 0;
  int fails  = 0;
  string phase = "reset";

  dual_lvds_packer i_dual_lvds_packer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .even_pix(even_pix), .odd_pix(odd_pix),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_take(pix_take),
    .even_lane(even_lane), .even_clk(even_clk), .odd_lane(odd_lane), .odd_clk(odd_clk)
  );

  always #5 clk = ~clk;

  // reference model: lane index 0..2 even data, 3 even clock, 4..6 odd data, 7 odd clock
  bit seq [0:7][0:6];
  bit m_started = 0;
  int m_pos = 0;
  bit m_hold = 0;
  bit last_take = 0;

  task automatic fill_link(int base, logic [17:0] p, bit with_ctl);
    // red is p[17:12], green p[11:6], blue p[5:0]
    seq[base][0] = p[6];
    for (int k = 0; k < 6; k++) seq[base][1+k] = p[17-k];
    seq[base+1][0] = p[1];
    seq[base+1][1] = p[0];
    for (int k = 0; k < 5; k++) seq[base+1][2+k] = p[11-k];
    seq[base+2][0] = with_ctl ? de : 1'b0;
    seq[base+2][1] = with_ctl ? vsync : 1'b0;
    seq[base+2][2] = with_ctl ? hsync : 1'b0;
    for (int k = 0; k < 4; k++) seq[base+2][3+k] = p[5-k];
    seq[base+3][0] = 1; seq[base+3][1] = 1; seq[base+3][2] = 0; seq[base+3][3] = 0;
    seq[base+3][4] = 0; seq[base+3][5] = 1; seq[base+3][6] = 1;
  endtask

  always @(posedge clk) begin
    m_hold = 0;
    if (rst) begin
      m_started = 0;
      m_pos = 0;
    end else if (bit_en) begin
      if (!m_started || m_pos == 6) begin
        fill_link(0, even_pix, 1'b1);
        fill_link(4, odd_pix, 1'b0);
        m_pos = 0;
        m_started = 1;
      end else begin
        m_pos = m_pos + 1;
      end
    end else begin
      m_hold = m_started;
    end
  end

  function automatic string lane_tag(int l);
    case (l)
      0, 4: return "R5";
      1, 5: return "R6";
      2:    return "R7";
      6:    return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic check_bit(string tag, int l, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] lane %0d actual %b expected %b at %0t", tag, phase, l, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] act;
    #2;
    act = {odd_clk, odd_lane, even_clk, even_lane};
    for (int l = 0; l < 8; l++) begin
      logic expb;
      string tag;
      expb = m_started ? seq[l][m_pos] : 1'b0;
      tag = !m_started ? "R1" : (m_hold ? "R3" : lane_tag(l));
      check_bit(tag, l, act[l], expb);
    end
    check_bit("R2", 8, pix_take, bit_en && !rst && (!m_started || m_pos == 6));
    last_take = pix_take;
  end

  int walk = 0;

  task automatic new_inputs(int pat);
    case (pat)
      0: begin
        even_pix = 18'($urandom); odd_pix = 18'($urandom);
        {hsync, vsync, de} = 3'($urandom);
      end
      1: begin
        even_pix = 18'(1) << (walk % 18);
        odd_pix  = 18'(1) << (17 - (walk % 18));
        {hsync, vsync, de} = 3'b000;
        walk++;
      end
      default: begin
        even_pix = '0; odd_pix = '0;
        {hsync, vsync, de} = 3'(1 << (walk % 3)) | 3'($urandom);
        walk++;
      end
    endcase
  endtask

  task automatic run(string ph, int n, int en_pct, bit every_cycle, int pat);
    phase = ph;
    repeat (n) begin
      @(negedge clk);
      #1;
      bit_en = (($urandom % 100) < en_pct);
      if (every_cycle || last_take) new_inputs(pat);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1; bit_en = 1;
    repeat (3) @(negedge clk);
    #1 rst = 0;
  endtask

  initial begin
    phase = "R1 reset";
    bit_en = 1;
    repeat (4) @(negedge clk);
    #1 rst = 0;
    run("R9 split pixels random", 400, 100, 0, 0);
    run("walking bit R5 R6 R7", 300, 100, 0, 1);
    run("sync only R8", 200, 100, 0, 2);
    run("gapped enable R3", 600, 50, 0, 0);
    run("R10 capture with moving inputs", 600, 70, 1, 0);
    do_reset();
    run("after mid-word reset R1", 300, 80, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule